// File: doc/BRIEF.md
# Channel Address Translator with Sticky Error Flags

This block turns a 26-bit system physical address into the 36-bit address that is carried on a memory channel, together with a broadcast flag. It also classifies each access as a plain memory access, a register access aimed at one module, or a register write aimed at every module. The translated request appears on registered outputs one cycle after the access strobe. Sending the packet on the bus is left to the logic downstream.

A small response tracker watches the channel's acknowledge and not-acknowledge lines after each request that expects a reply. It decides when an acknowledge is missing and when a not-acknowledge arrives with nothing outstanding. A missing reply on a read turns into an all-zero data result, and on a write the write is dropped. Three sticky error flags record over-range accesses, stray not-acknowledges and missing acknowledges. Any write to the error port clears them, and a new event in the same cycle takes priority over the clear.

Top module: `chan_xlate_top`

## Requirements
- R1: An address below 0x3F00000 is a memory access: `out_addr` is the system address zero-extended to 36 bits, `out_kind` is 2'b00 and `out_bcast` is 0.
- R2: An address from 0x3F00000 up is a register access. The 9-bit field taken from system bits 18:10 is placed at channel bits 28:20 and again at 19:11. System bits 9:0 go to channel bits 9:0, and every other channel bit is 0.
- R3: In register space, system bit 19 is the broadcast flag. When it is 0, `out_kind` is 2'b01 and `out_bcast` is 0. When it is 1, `out_kind` is 2'b10 and `out_bcast` is 1.
- R4: After reset, `out_valid`, `zero_fill`, `wr_drop` and `err_flags` are all 0.
- R5: `out_valid` pulses for exactly one cycle, in the cycle after a clock edge that sampled `req_valid`. `out_write` carries the sampled `req_write`.
- R6: A memory access with an address from 0x0800000 to 0x3EFFFFF sets error bit 2 (`err_flags[2]`). The request is still issued with its normal translation.
- R7: A non-broadcast request expects a reply at one of the WIN clock edges that follow its issuing edge (default WIN = 8). If neither ack nor nack arrives by the WIN-th edge, error bit 0 is set at that edge. An ack at that last edge avoids the error.
- R8: When the reply window expires, `zero_fill` pulses for one cycle if the request was a read, and `wr_drop` pulses for one cycle if it was a write.
- R9: A nack sampled while no request is pending sets error bit 1. A nack inside a reply window ends the window and sets no error bit.
- R10: A broadcast register write expects no reply, so it never sets error bit 0.
- R11: The error bits are sticky. A clock edge with `err_clr_wr` high clears all three bits, except for any bit whose event is sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_addr | input | 26 | System physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_ack | input | 1 | Acknowledge from the channel |
| rsp_nack | input | 1 | Not-acknowledge from the channel |
| err_clr_wr | input | 1 | Write strobe to the error register (clears it) |
| out_valid | output | 1 | Translated request valid |
| out_addr | output | 36 | Channel address |
| out_bcast | output | 1 | Broadcast register write flag |
| out_kind | output | 2 | 00 memory, 01 register, 10 broadcast register |
| out_write | output | 1 | Direction of the translated request |
| zero_fill | output | 1 | Read got no reply; data returned as zero |
| wr_drop | output | 1 | Write got no reply; write dropped |
| err_flags | output | 3 | bit 2 over-range, bit 1 stray nack, bit 0 missing ack |

## Verification
The translation is driven with addresses at the edges of every region: zero, a mid-range memory word, the last address below the over-range threshold, both ends of the over-range band, and the first, last and broadcast-switching addresses of register space. These separate the identity mapping, the duplicated 9-bit field and the bit-19 broadcast choice. Directed reply sequences cover a missing ack on a read and on a write, an ack on the last edge of the window, a nack inside and outside a window, and a broadcast write left unanswered. These show where the window edge lies and which replies count as expected. Finally, a clear and a new event at the same edge show that the event wins over the clear.

// File: rtl/chan_xlate_pkg.sv
package chan_xlate_pkg;

    localparam int SYS_AW  = 26;
    localparam int CHAN_AW = 36;

    typedef enum logic [1:0] {
        KIND_MEM   = 2'b00,
        KIND_REG   = 2'b01,
        KIND_BCAST = 2'b10
    } acc_kind_e;

    typedef struct packed {
        logic [CHAN_AW-1:0] adr;
        logic               bcast;
        acc_kind_e          kind;
        logic               write;
        logic               over;
    } chan_req_t;

endpackage

// File: rtl/chan_addr_map.sv
module chan_addr_map
    import chan_xlate_pkg::*;
#(
    parameter logic [SYS_AW-1:0] MAP_LIMIT = 26'h0800000
) (
    input  logic [SYS_AW-1:0] addr,
    input  logic              write,
    output chan_req_t         req
);
    localparam int SPACE_LSB = 20;
    localparam int BC_BIT    = 19;
    localparam int FIELD_LSB = 10;
    localparam int FIELD_W   = 9;
    localparam int OFF_W     = 10;
    localparam int ROW_LSB   = 20;
    localparam int COL_LSB   = 11;
    localparam int SPACE_W   = SYS_AW - SPACE_LSB;

    logic               reg_space;
    logic [FIELD_W-1:0] field;

    always_comb begin
        reg_space = (addr[SYS_AW-1:SPACE_LSB] == {SPACE_W{1'b1}});
        field     = addr[FIELD_LSB +: FIELD_W];
        req       = '0;
        req.write = write;
        if (reg_space) begin
            req.adr[ROW_LSB +: FIELD_W] = field;
            req.adr[COL_LSB +: FIELD_W] = field;
            req.adr[OFF_W-1:0]          = addr[OFF_W-1:0];
            req.bcast                   = addr[BC_BIT];
            req.kind                    = addr[BC_BIT] ? KIND_BCAST : KIND_REG;
        end else begin
            req.adr  = CHAN_AW'(addr);
            req.kind = KIND_MEM;
            req.over = (addr >= MAP_LIMIT);
        end
    end
endmodule

// File: rtl/chan_rsp_track.sv
module chan_rsp_track #(
    parameter int WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic expect_rsp,
    input  logic is_write,
    input  logic ack,
    input  logic nack,
    output logic miss_evt,
    output logic stray_nack_evt,
    output logic zero_fill,
    output logic wr_drop
);
    localparam int CNT_W = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN - 1);

    typedef struct packed {
        logic             pending;
        logic [CNT_W-1:0] cnt;
        logic             was_write;
        logic             zero_fill;
        logic             wr_drop;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.zero_fill = 1'b0;
        st_d.wr_drop   = 1'b0;
        miss_evt       = 1'b0;
        stray_nack_evt = nack && !st_q.pending;
        if (issue) begin
            st_d.pending   = expect_rsp;
            st_d.cnt       = '0;
            st_d.was_write = is_write;
        end else if (st_q.pending) begin
            if (ack || nack) begin
                st_d.pending = 1'b0;
            end else if (st_q.cnt == LAST) begin
                st_d.pending   = 1'b0;
                miss_evt       = 1'b1;
                st_d.zero_fill = !st_q.was_write;
                st_d.wr_drop   = st_q.was_write;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zero_fill = st_q.zero_fill;
    assign wr_drop   = st_q.wr_drop;
endmodule

// File: rtl/chan_err_reg.sv
module chan_err_reg #(
    parameter int NERR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NERR-1:0] set_evt,
    input  logic            clr,
    output logic [NERR-1:0] flags
);
    logic [NERR-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (clr ? '0 : flags_q) | set_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/chan_xlate_top.sv
module chan_xlate_top
    import chan_xlate_pkg::*;
#(
    parameter int                WIN       = 8,
    parameter logic [SYS_AW-1:0] MAP_LIMIT = 26'h0800000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [SYS_AW-1:0]  req_addr,
    input  logic               req_write,
    input  logic               rsp_ack,
    input  logic               rsp_nack,
    input  logic               err_clr_wr,
    output logic               out_valid,
    output logic [CHAN_AW-1:0] out_addr,
    output logic               out_bcast,
    output logic [1:0]         out_kind,
    output logic               out_write,
    output logic               zero_fill,
    output logic               wr_drop,
    output logic [2:0]         err_flags
);
    localparam int NERR    = 3;
    localparam int E_OVER  = 2;
    localparam int E_NACK  = 1;
    localparam int E_MISS  = 0;

    typedef struct packed {
        logic      vld;
        chan_req_t req;
    } out_t;

    chan_req_t       map_req;
    out_t            out_d, out_q;
    logic            miss_evt, stray_evt;
    logic [NERR-1:0] evt;

    chan_addr_map #(.MAP_LIMIT(MAP_LIMIT)) u_map (
        .addr  (req_addr),
        .write (req_write),
        .req   (map_req)
    );

    chan_rsp_track #(.WIN(WIN)) u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue          (req_valid),
        .expect_rsp     (map_req.kind != KIND_BCAST),
        .is_write       (req_write),
        .ack            (rsp_ack),
        .nack           (rsp_nack),
        .miss_evt       (miss_evt),
        .stray_nack_evt (stray_evt),
        .zero_fill      (zero_fill),
        .wr_drop        (wr_drop)
    );

    always_comb begin
        evt         = '0;
        evt[E_OVER] = req_valid && map_req.over;
        evt[E_NACK] = stray_evt;
        evt[E_MISS] = miss_evt;
        out_d       = out_q;
        out_d.vld   = req_valid;
        if (req_valid) out_d.req = map_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    chan_err_reg #(.NERR(NERR)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (evt),
        .clr     (err_clr_wr),
        .flags   (err_flags)
    );

    assign out_valid = out_q.vld;
    assign out_addr  = out_q.req.adr;
    assign out_bcast = out_q.req.bcast;
    assign out_kind  = out_q.req.kind;
    assign out_write = out_q.req.write;
endmodule

// File: rtl/chan_xlate_chk.sv
module chan_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        err_clr_wr,
    input logic        out_valid,
    input logic [35:0] out_addr,
    input logic        out_bcast,
    input logic [1:0]  out_kind,
    input logic        out_write,
    input logic        zero_fill,
    input logic        wr_drop,
    input logic [2:0]  err_flags
);
    // R5
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));

    // R5
    dir_carried_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_write == $past(req_write)));

    // R3
    bcast_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_kind == 2'b10) == out_bcast));

    // R1
    mem_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b00) |-> (out_addr[35:26] == '0));

    // R2
    reg_field_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'b00) |-> (out_addr[28:20] == out_addr[19:11] && out_addr[10] == 1'b0));

    // R8
    miss_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(zero_fill && wr_drop));

    // R8
    miss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_fill || wr_drop) |-> err_flags[0]);

    // R11
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(err_flags) & ~err_flags)) |-> $past(err_clr_wr));
endmodule

bind chan_xlate_top chan_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .err_clr_wr (err_clr_wr),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_bcast  (out_bcast),
    .out_kind   (out_kind),
    .out_write  (out_write),
    .zero_fill  (zero_fill),
    .wr_drop    (wr_drop),
    .err_flags  (err_flags)
);

// File: tb/test_chan_xlate_top.sv
module test_chan_xlate_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 8;

    typedef struct packed {
        logic [25:0] a;
        logic [35:0] adr;
        logic [1:0]  kind;
        logic        bc;
        logic        over;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{26'h0000000, 36'h000000000, 2'd0, 1'b0, 1'b0},
        '{26'h03ABCDE, 36'h0003ABCDE, 2'd0, 1'b0, 1'b0},
        '{26'h07FFFFF, 36'h0007FFFFF, 2'd0, 1'b0, 1'b0},
        '{26'h0800000, 36'h000800000, 2'd0, 1'b0, 1'b1},
        '{26'h3EFFFFF, 36'h003EFFFFF, 2'd0, 1'b0, 1'b1},
        '{26'h3F00808, 36'h000201008, 2'd1, 1'b0, 1'b0},
        '{26'h3F00400, 36'h000100800, 2'd1, 1'b0, 1'b0},
        '{26'h3F7FFFF, 36'h01FFFFBFF, 2'd1, 1'b0, 1'b0},
        '{26'h3F80008, 36'h000000008, 2'd2, 1'b1, 1'b0},
        '{26'h3FFFFFF, 36'h01FFFFBFF, 2'd2, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [25:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_ack = 1'b0;
    logic        rsp_nack = 1'b0;
    logic        err_clr_wr = 1'b0;
    logic        out_valid;
    logic [35:0] out_addr;
    logic        out_bcast;
    logic [1:0]  out_kind;
    logic        out_write;
    logic        zero_fill;
    logic        wr_drop;
    logic [2:0]  err_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_xlate_top #(.WIN(WIN)) i_chan_xlate_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .rsp_ack(rsp_ack), .rsp_nack(rsp_nack),
        .err_clr_wr(err_clr_wr), .out_valid(out_valid), .out_addr(out_addr),
        .out_bcast(out_bcast), .out_kind(out_kind), .out_write(out_write),
        .zero_fill(zero_fill), .wr_drop(wr_drop), .err_flags(err_flags)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [25:0] a, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr_wr = 1'b1;
        @(negedge clk);
        err_clr_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4 reset state
        chk("R4 out_valid", 64'(out_valid), 64'd0);
        chk("R4 err_flags", 64'(err_flags), 64'd0);
        chk("R4 zero_fill", 64'(zero_fill), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 err after release", 64'(err_flags), 64'd0);

        // table walk: R1 R2 R3 R5 R6
        for (int i = 0; i < NV; i++) begin
            clear_err();
            issue(VECS[i].a, i[0]);
            chk("R5 out_valid", 64'(out_valid), 64'd1);
            chk("R5 out_write", 64'(out_write), 64'(i[0]));
            chk(VECS[i].kind == 2'd0 ? "R1 out_addr" : "R2 out_addr", 64'(out_addr), 64'(VECS[i].adr));
            chk("R3 out_kind", 64'(out_kind), 64'(VECS[i].kind));
            chk("R3 out_bcast", 64'(out_bcast), 64'(VECS[i].bc));
            chk("R6 over flag", 64'(err_flags[2]), 64'(VECS[i].over));
            if (VECS[i].kind != 2'd2) pulse_ack();
            else @(negedge clk);
            chk("R5 single pulse", 64'(out_valid), 64'd0);
            chk("R7 acked no miss", 64'(err_flags), {61'd0, VECS[i].over, 2'b00});
        end

        // R7 R8 read with no reply
        clear_err();
        issue(26'h0001000, 1'b0);
        repeat (WIN-1) @(negedge clk);
        chk("R7 before window end", 64'(err_flags[0]), 64'd0);
        @(negedge clk);
        chk("R7 miss at window end", 64'(err_flags[0]), 64'd1);
        chk("R8 zero_fill pulse", 64'(zero_fill), 64'd1);
        chk("R8 no wr_drop on read", 64'(wr_drop), 64'd0);
        @(negedge clk);
        chk("R8 zero_fill one cycle", 64'(zero_fill), 64'd0);
        repeat (4) @(negedge clk);
        chk("R11 sticky miss", 64'(err_flags), 64'b001);

        // R8 write with no reply
        clear_err();
        issue(26'h0002000, 1'b1);
        repeat (WIN) @(negedge clk);
        chk("R8 wr_drop pulse", 64'(wr_drop), 64'd1);
        chk("R8 no zero_fill on write", 64'(zero_fill), 64'd0);

        // R7 ack on last edge of window
        clear_err();
        issue(26'h3F00808, 1'b0);
        repeat (WIN-1) @(negedge clk);
        pulse_ack();
        repeat (3) @(negedge clk);
        chk("R7 late ack in window", 64'(err_flags), 64'd0);

        // R9 nack inside window
        clear_err();
        issue(26'h0004000, 1'b0);
        rsp_nack = 1'b1;
        @(negedge clk);
        rsp_nack = 1'b0;
        repeat (WIN+2) @(negedge clk);
        chk("R9 nack in window", 64'(err_flags), 64'd0);

        // R9 stray nack
        rsp_nack = 1'b1;
        @(negedge clk);
        rsp_nack = 1'b0;
        chk("R9 stray nack", 64'(err_flags), 64'b010);

        // R10 broadcast left unanswered
        clear_err();
        issue(26'h3F80008, 1'b1);
        repeat (WIN+3) @(negedge clk);
        chk("R10 bcast no miss", 64'(err_flags), 64'd0);
        chk("R10 bcast no drop", 64'(wr_drop), 64'd0);

        // R11 clear versus same-edge event
        issue(26'h0900000, 1'b0);
        pulse_ack();
        rsp_nack = 1'b1;
        @(negedge clk);
        rsp_nack = 1'b0;
        chk("R11 setup", 64'(err_flags), 64'b110);
        err_clr_wr = 1'b1; rsp_nack = 1'b1;
        @(negedge clk);
        err_clr_wr = 1'b0; rsp_nack = 1'b0;
        chk("R11 event beats clear", 64'(err_flags), 64'b010);
        clear_err();
        chk("R11 plain clear", 64'(err_flags), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule